// File: doc/BRIEF.md
# Per-Channel Signaling Code Store with Source Selection

This block holds one four-bit signaling code (D, C, B, A) for each channel of a single link, up to 32 channels. A configuration register picks where new codes come from: the host port alone, a receive-system code stream, or codes pulled from the receive line. Whatever the source, the host may overwrite any channel at any time. A read port returns the stored code of any channel without delay.

Codes taken from the line can pass through a per-channel debounce filter. With the filter on, a code is stored only once the same value has arrived twice in a row for that channel. Selecting the host as the source stops all live updates, so the codes last stored stay frozen until the host writes them or a live source is selected again. When the source leaves the line, the filter forgets every pending candidate.

Top module: `chan_sig_src_sel`

## Requirements
- R1: After reset every stored code reads 0 and the source is host (source code 0), so system and line inputs have no effect.
- R2: A host write (`host_we_i`) stores `host_code_i` into channel `host_ch_i` on the next clock edge, whatever the source.
- R3: With source code 1 (receive system), each cycle with `sys_vld_i` high copies `sys_code_i` unchanged into channel `sys_ch_i`.
- R4: With source code 0 (host) the system and line inputs are ignored, and the stored codes stay as they were until the host writes them.
- R5: With source code 2 (receive line) and debounce on, a line code is stored only when the previous valid line sample for the same channel carried the same value; a different value becomes the new candidate and stores nothing.
- R6: With source code 2 and debounce off, each valid line sample is stored at once.
- R7: Line samples with `line_vld_i` low are ignored; in source 1 line samples are ignored, and in source 2 system samples are ignored.
- R8: When a host write and a live update hit the same channel in one cycle, the host code is kept; when they hit different channels, both are stored.
- R9: Source code 3 behaves exactly as host.
- R10: Leaving source 2 clears all debounce candidates, so after returning to source 2 the first sample of a channel is not stored even if it equals the one last seen.
- R11: `rd_code_o` returns the stored code of channel `rd_ch_i` in the same cycle, with D, C, B, A in bits 3, 2, 1, 0.
- R12: A configuration write (`cfg_we_i`) sets the source (`cfg_src_i`) and debounce enable (`cfg_deb_i`), both of which act from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | 2 | Source: 0 host, 1 receive system, 2 receive line, 3 host |
| cfg_deb_i | input | 1 | Debounce enable for line codes |
| host_we_i | input | 1 | Host code write strobe |
| host_ch_i | input | 5 | Host write channel |
| host_code_i | input | 4 | Host write code (D,C,B,A) |
| sys_vld_i | input | 1 | Receive-system code valid |
| sys_ch_i | input | 5 | Receive-system channel |
| sys_code_i | input | 4 | Receive-system code |
| line_vld_i | input | 1 | Receive-line code valid |
| line_ch_i | input | 5 | Receive-line channel |
| line_code_i | input | 4 | Receive-line code |
| rd_ch_i | input | 5 | Readout channel |
| rd_code_o | output | 4 | Stored code of the readout channel |

## Verification
A host write and a live update can land in the same cycle. The bench drives both in one cycle, first on one channel and then on two different channels, in receive-system mode and in line mode with debounce off, and judges by reading every channel back: the host code must win on a shared channel and both codes must appear on separate channels. Source changes that fall between two line samples of a channel are provoked to show that the debounce candidate is dropped.

// File: rtl/sigsel_pkg.sv
package sigsel_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_LINE = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/sigsel_cfg.sv
module sigsel_cfg
  import sigsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_src_i,
  input  logic       cfg_deb_i,
  output src_e       src_o,
  output logic       deb_o
);
  src_e src_q, src_n;
  logic deb_q, deb_n;

  always_comb begin
    src_n = src_q;
    deb_n = deb_q;
    if (cfg_we_i) begin
      src_n = src_e'(cfg_src_i);
      deb_n = cfg_deb_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_HOST;
      deb_q <= 1'b0;
    end else begin
      src_q <= src_n;
      deb_q <= deb_n;
    end
  end

  assign src_o = src_q;
  assign deb_o = deb_q;
endmodule

// File: rtl/sigsel_deb.sv
module sigsel_deb #(
  parameter int NCH = 32,
  parameter int CW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_en_i,
  input  logic           deb_en_i,
  input  logic           vld_i,
  input  logic [CHW-1:0] ch_i,
  input  logic [CW-1:0]  code_i,
  output logic           acc_o
);
  logic [CW-1:0] cand_q [NCH];
  logic [CW-1:0] cand_n [NCH];
  logic          cv_q   [NCH];
  logic          cv_n   [NCH];
  logic          ch_ok;
  logic          match;

  assign ch_ok = (32'(ch_i) < NCH);

  always_comb begin
    match = 1'b0;
    if (ch_ok) match = cv_q[ch_i] && (cand_q[ch_i] == code_i);
  end

  assign acc_o = line_en_i && vld_i && ch_ok && (!deb_en_i || match);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CHW-1:0] IDX = CHW'(i);
    logic hit;
    assign hit = line_en_i && vld_i && (ch_i == IDX);

    always_comb begin
      cand_n[i] = cand_q[i];
      cv_n[i]   = cv_q[i];
      if (!line_en_i) begin
        cv_n[i] = 1'b0;
      end else if (hit) begin
        cand_n[i] = code_i;
        cv_n[i]   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cand_q[i] <= '0;
        cv_q[i]   <= 1'b0;
      end else begin
        cand_q[i] <= cand_n[i];
        cv_q[i]   <= cv_n[i];
      end
    end
  end
endmodule

// File: rtl/sigsel_bank.sv
module sigsel_bank #(
  parameter int NCH = 32,
  parameter int CW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwe_i,
  input  logic [CHW-1:0]    hch_i,
  input  logic [CW-1:0]     hcode_i,
  input  logic              lwe_i,
  input  logic [CHW-1:0]    lch_i,
  input  logic [CW-1:0]     lcode_i,
  input  logic [CHW-1:0]    rd_ch_i,
  output logic [CW-1:0]     rd_code_o,
  output logic [NCH*CW-1:0] codes_o
);
  logic [CW-1:0] code_q [NCH];
  logic [CW-1:0] code_n [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CHW-1:0] IDX = CHW'(i);
    logic h_hit, l_hit, en;
    assign h_hit = hwe_i && (hch_i == IDX);
    assign l_hit = lwe_i && (lch_i == IDX);
    assign en    = h_hit || l_hit;

    always_comb begin
      code_n[i] = code_q[i];
      if (h_hit)      code_n[i] = hcode_i;
      else if (l_hit) code_n[i] = lcode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q[i] <= '0;
      else if (en) code_q[i] <= code_n[i];
    end

    assign codes_o[i*CW +: CW] = code_q[i];
  end

  always_comb begin
    rd_code_o = '0;
    if (32'(rd_ch_i) < NCH) rd_code_o = code_q[rd_ch_i];
  end
endmodule

// File: rtl/chan_sig_src_sel.sv
module chan_sig_src_sel
  import sigsel_pkg::*;
#(
  parameter int NCH = 32,
  parameter int CW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_src_i,
  input  logic           cfg_deb_i,
  input  logic           host_we_i,
  input  logic [CHW-1:0] host_ch_i,
  input  logic [CW-1:0]  host_code_i,
  input  logic           sys_vld_i,
  input  logic [CHW-1:0] sys_ch_i,
  input  logic [CW-1:0]  sys_code_i,
  input  logic           line_vld_i,
  input  logic [CHW-1:0] line_ch_i,
  input  logic [CW-1:0]  line_code_i,
  input  logic [CHW-1:0] rd_ch_i,
  output logic [CW-1:0]  rd_code_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  src_e              src_q;
  logic              deb_q;
  logic              line_en;
  logic              line_acc;
  logic              live_we;
  logic [CHW-1:0]    live_ch;
  logic [CW-1:0]     live_code;
  logic [NCH*CW-1:0] codes_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  sigsel_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cfg_we_i  (cfg_we_i),
    .cfg_src_i (cfg_src_i),
    .cfg_deb_i (cfg_deb_i),
    .src_o     (src_q),
    .deb_o     (deb_q)
  );

  assign line_en = (src_q == SRC_LINE);

  sigsel_deb #(.NCH(NCH), .CW(CW)) u_deb (
    .clk       (clk),
    .rst_n     (rst_sn),
    .line_en_i (line_en),
    .deb_en_i  (deb_q),
    .vld_i     (line_vld_i),
    .ch_i      (line_ch_i),
    .code_i    (line_code_i),
    .acc_o     (line_acc)
  );

  always_comb begin
    live_we   = 1'b0;
    live_ch   = sys_ch_i;
    live_code = sys_code_i;
    unique case (src_q)
      SRC_SYS: live_we = sys_vld_i;
      SRC_LINE: begin
        live_we   = line_acc;
        live_ch   = line_ch_i;
        live_code = line_code_i;
      end
      default: live_we = 1'b0;
    endcase
  end

  sigsel_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sn),
    .hwe_i     (host_we_i),
    .hch_i     (host_ch_i),
    .hcode_i   (host_code_i),
    .lwe_i     (live_we),
    .lch_i     (live_ch),
    .lcode_i   (live_code),
    .rd_ch_i   (rd_ch_i),
    .rd_code_o (rd_code_o),
    .codes_o   (codes_flat)
  );
endmodule

// File: rtl/sigsel_chk.sv
module sigsel_chk #(
  parameter int NCH = 32,
  parameter int CW  = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        src,
  input logic              deb,
  input logic              host_we_i,
  input logic [CHW-1:0]    host_ch_i,
  input logic [CW-1:0]     host_code_i,
  input logic              sys_vld_i,
  input logic [CHW-1:0]    sys_ch_i,
  input logic [CW-1:0]     sys_code_i,
  input logic              line_vld_i,
  input logic [CHW-1:0]    line_ch_i,
  input logic [CW-1:0]     line_code_i,
  input logic [NCH*CW-1:0] codes
);
  logic host_like;
  assign host_like = (src == 2'd0) || (src == 2'd3);

  function automatic logic [CW-1:0] code_at(input logic [CHW-1:0] c);
    return codes[32'(c)*CW +: CW];
  endfunction

  // R4
  host_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_like && !host_we_i) |=> $stable(codes));

  // R2
  host_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we_i |=> (code_at($past(host_ch_i)) == $past(host_code_i)));

  // R3
  sys_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd1 && sys_vld_i && !(host_we_i && host_ch_i == sys_ch_i))
    |=> (code_at($past(sys_ch_i)) == $past(sys_code_i)));

  // R6
  line_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd2 && !deb && line_vld_i && !(host_we_i && host_ch_i == line_ch_i))
    |=> (code_at($past(line_ch_i)) == $past(line_code_i)));

  // R7
  sys_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd1 && !sys_vld_i && !host_we_i) |=> $stable(codes));
endmodule

bind chan_sig_src_sel sigsel_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sn),
  .src         (src_q),
  .deb         (deb_q),
  .host_we_i   (host_we_i),
  .host_ch_i   (host_ch_i),
  .host_code_i (host_code_i),
  .sys_vld_i   (sys_vld_i),
  .sys_ch_i    (sys_ch_i),
  .sys_code_i  (sys_code_i),
  .line_vld_i  (line_vld_i),
  .line_ch_i   (line_ch_i),
  .line_code_i (line_code_i),
  .codes       (codes_flat)
);

// File: tb/chan_sig_src_sel_tb.sv
`timescale 1ns/1ps
module chan_sig_src_sel_tb_top;
  localparam int NCH = 32;
  localparam int CW  = 4;
  localparam int CHW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cw, cdeb, hw, sv, lv;
  logic [1:0] csrc;
  logic [CHW-1:0] hch, sch, lch, rch;
  logic [CW-1:0] hcode, scode, lcode, rcode;

  int total = 0;
  int bad = 0;

  logic [1:0]    m_src;
  logic          m_deb;
  logic [CW-1:0] m_code [NCH];
  logic [CW-1:0] m_cand [NCH];
  logic          m_cv   [NCH];

  always #2 clk = ~clk;

  chan_sig_src_sel #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cw), .cfg_src_i(csrc), .cfg_deb_i(cdeb),
    .host_we_i(hw), .host_ch_i(hch), .host_code_i(hcode),
    .sys_vld_i(sv), .sys_ch_i(sch), .sys_code_i(scode),
    .line_vld_i(lv), .line_ch_i(lch), .line_code_i(lcode),
    .rd_ch_i(rch), .rd_code_o(rcode)
  );

  task automatic idle();
    cw = 0; hw = 0; sv = 0; lv = 0;
  endtask

  // One clock of stimulus; the model follows the requirements.
  task automatic tick();
    logic acc;
    logic [1:0] old_src;
    acc = 1'b0;
    old_src = m_src;
    if (m_src == 2'd2 && lv) begin
      if (!m_deb) acc = 1'b1;
      else if (m_cv[lch] && m_cand[lch] == lcode) acc = 1'b1;
    end
    @(posedge clk);
    if (old_src == 2'd2 && lv) begin m_cand[lch] = lcode; m_cv[lch] = 1'b1; end
    if (old_src == 2'd1 && sv) m_code[sch] = scode;
    if (acc) m_code[lch] = lcode;
    if (hw) m_code[hch] = hcode;
    if (cw) begin m_src = csrc; m_deb = cdeb; end
    if (old_src != 2'd2 || m_src != 2'd2)
      for (int i = 0; i < NCH; i++) m_cv[i] = 1'b0;
    #1;
    idle();
  endtask

  task automatic cfg(input logic [1:0] s, input logic d);
    cw = 1; csrc = s; cdeb = d; tick();
  endtask

  task automatic host_wr(input int c, input logic [CW-1:0] v);
    hw = 1; hch = CHW'(c); hcode = v; tick();
  endtask

  task automatic sys_wr(input int c, input logic [CW-1:0] v);
    sv = 1; sch = CHW'(c); scode = v; tick();
  endtask

  task automatic line_smp(input int c, input logic [CW-1:0] v);
    lv = 1; lch = CHW'(c); lcode = v; tick();
  endtask

  // R11: readout of every channel against the model
  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      rch = CHW'(c);
      #1;
      total++;
      if (rcode !== m_code[c]) begin
        bad++;
        $display("FAIL %s ch=%0d actual=%h expected=%h", tag, c, rcode, m_code[c]);
      end
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    csrc = 0; cdeb = 0; hch = 0; sch = 0; lch = 0; rch = 0;
    hcode = 0; scode = 0; lcode = 0;
    m_src = 0; m_deb = 0;
    for (int i = 0; i < NCH; i++) begin m_code[i] = 0; m_cand[i] = 0; m_cv[i] = 0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 reset");
    sys_wr(3, 4'h9);
    line_smp(4, 4'h7);
    check_all("R1 source host");

    for (int c = 0; c < NCH; c++) host_wr(c, CW'((c * 7 + 1) & 15));
    check_all("R2 host sweep");

    cfg(2'd1, 1'b0);  // R12
    for (int c = 0; c < NCH; c++) sys_wr(c, CW'((c * 3 + 2) & 15));
    check_all("R3 system copy");
    line_smp(5, 4'h0);
    check_all("R7 line in system mode");
    host_wr(9, 4'h1);
    check_all("R2 host write in system mode");

    hw = 1; hch = 4; hcode = 4'hA; sv = 1; sch = 4; scode = 4'h5; tick();
    hw = 1; hch = 6; hcode = 4'hC; sv = 1; sch = 7; scode = 4'h3; tick();
    check_all("R8 system collision");

    cfg(2'd0, 1'b0);
    for (int c = 0; c < 4; c++) sys_wr(c, 4'hF);
    check_all("R4 host freeze");

    cfg(2'd3, 1'b0);
    sys_wr(8, 4'hE);
    line_smp(8, 4'hD);
    check_all("R9 reserved source");

    cfg(2'd2, 1'b0);
    line_smp(10, 4'hC);
    check_all("R6 line direct");
    sys_wr(10, 4'h2);
    lv = 0; lch = 11; lcode = 4'h8; tick();
    check_all("R7 ignored inputs in line mode");
    hw = 1; hch = 12; hcode = 4'h6; lv = 1; lch = 12; lcode = 4'h9; tick();
    hw = 1; hch = 13; hcode = 4'h4; lv = 1; lch = 14; lcode = 4'hB; tick();
    check_all("R8 line collision");

    cfg(2'd2, 1'b1);
    line_smp(11, 4'h6);
    check_all("R5 first sample held");
    line_smp(12, 4'h3);
    line_smp(11, 4'h6);
    line_smp(12, 4'h4);
    line_smp(12, 4'h3);
    check_all("R5 changed sample restarts");
    line_smp(12, 4'h3);
    check_all("R5 repeated sample stored");
    for (int c = 0; c < NCH; c++) line_smp(c, CW'((c ^ 9) & 15));
    for (int c = 0; c < NCH; c++) line_smp(c, CW'((c ^ 9) & 15));
    check_all("R5 sweep");

    line_smp(13, 4'h1);
    cfg(2'd0, 1'b1);
    line_smp(13, 4'h1);
    check_all("R4 freeze from line");
    cfg(2'd2, 1'b1);
    line_smp(13, 4'h1);
    check_all("R10 candidate cleared");
    line_smp(13, 4'h1);
    check_all("R10 stored after two");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule